// File: doc/BRIEF.md
# Double-Buffered Serial Converter Code Interface

This block is the digital front end of a serial-input converter with a 16-bit code. A word arrives one bit at a time on a data pin, most significant bit first, in straight binary. It is clocked by the rising edges of a gated shift clock, which is the OR of the active-low select and the serial clock. Two storage stages follow the shift register. The first is an input register that follows the shift register while the load strobe is low and holds while it is high. The second is the code register, which takes the input register's value on a rising edge of the update strobe. A rising edge on the clear pin forces both stages to mid-scale or to zero, according to a select pin. The shift register's top bit drives a serial output, so several instances can be chained.

All pins are sampled by the system clock `clk`. An edge on any strobe is acted on at the clock edge where the pin is first seen high after having been seen low. The system reset `rst_n` clears every register and arms the edge detectors. Before the first clear edge, software should treat the code as undefined.

Top module: `sdac_frontend`

## Requirements
- R1: A 16-bit word shifted in MSB first and then loaded and updated appears unchanged at `code_out`. Bit 15 is the first bit sent.
- R2: The shift register advances one bit, taking `sdi` into bit 0, on each rising edge of (`cs_n` OR `sclk`). Toggling `sclk` with `cs_n` low and toggling `cs_n` with `sclk` low are equally valid ways to shift.
- R3: A rise of `cs_n` while `sclk` is low is a rising edge of the gated clock, so it shifts one extra bit.
- R4: While `load_n` is low, the input register takes the shift register value in the same clock, including while bits are being shifted.
- R5: While `load_n` is high, the input register holds. An update then transfers the old input value.
- R6: A rising edge of `upd` copies the input register into `code_out`. An `upd` held high or low leaves `code_out` unchanged.
- R7: A rising edge of `clr_in` sets both the input register and `code_out` to 16'h8000 when `clr_mid` is 1, and to 16'h0000 when `clr_mid` is 0. It takes priority over load and update.
- R8: A `clr_in` edge leaves the shift register contents unchanged.
- R9: `sdo` equals bit 15 of the shift register and changes only on a gated-clock rising edge. After k further shifts it shows bit 15-k of the earlier contents.
- R10: After `rst_n` is released, `code_out` and `sdo` are 0. A strobe pin that is already high when reset ends is not counted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock, ORed with `cs_n` |
| cs_n | input | 1 | Active-low select, ORed with `sclk` |
| sdi | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Input register transparent while low |
| upd | input | 1 | Rising edge moves input register to code |
| clr_in | input | 1 | Rising edge presets input and code registers |
| clr_mid | input | 1 | Preset target: 1 mid-scale, 0 zero |
| sdo | output | 1 | Shift register top bit, for chaining |
| code_out | output | 16 | Code register contents |

## Verification
The bench builds the block at its default width of 16. This makes the mid-scale value 16'h8000 and lets the sixteen-shift daisy-chain walk of `sdo` be compared bit by bit with a known earlier word. At this width the extra shift from a late select rise is also visible as a one-place offset in a loaded word. A behavioural model tracks the shift, input and code registers on every clock, so loads during shifting, presets racing loads, and strobes held high are all covered by the same comparison.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    // Lane order of the strobe edge detector.
    localparam int LANE_SHIFT = 0;
    localparam int LANE_UPD   = 1;
    localparam int LANE_CLR   = 2;
    localparam int N_LANES    = 3;
endpackage

// File: rtl/sdac_edge.sv
module sdac_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = lvl;
        rise     = lvl & ~e_q.prev;
    end

    // Reset arms all lanes high: a line high at reset exit is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{prev: '1};
        else        e_q <= e_d;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            a_r10_no_double: assert property (@(posedge clk) disable iff (!rst_n)
                rise[i] |=> !rise[i]);
        end
    endgenerate
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         din,
    output logic [W-1:0] word_d,
    output logic         dout
);
    typedef struct packed {
        logic [W-1:0] sr;
    } sh_st_t;

    sh_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv) s_d.sr = {s_q.sr[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_d = s_d.sr;
    assign dout   = s_q.sr[W-1];

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (s_q.sr == {$past(s_q.sr[W-2:0]), $past(din)}));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(s_q.sr));
    a_r9_sdo_moves_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dout));
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_d,
    input  logic         follow,
    input  logic         xfer,
    input  logic         preset,
    input  logic         preset_mid,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ZERO_CODE = '0;

    typedef struct packed {
        logic [W-1:0] inreg;
        logic [W-1:0] code;
    } rg_st_t;

    rg_st_t r_d, r_q;
    logic [W-1:0] target;

    always_comb begin
        r_d    = r_q;
        target = preset_mid ? MID_CODE : ZERO_CODE;
        if (preset) begin
            r_d.inreg = target;
            r_d.code  = target;
        end else begin
            if (follow) r_d.inreg = word_d;
            if (xfer)   r_d.code  = r_q.inreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code = r_q.code;

    a_r7_preset: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (r_q.code == ($past(preset_mid) ? MID_CODE : ZERO_CODE))
                   && (r_q.inreg == r_q.code));
    a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !preset) |=> (r_q.code == $past(r_q.inreg)));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !preset) |=> $stable(r_q.code));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!follow && !preset) |=> $stable(r_q.inreg));
    a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && !preset) |=> (r_q.inreg == $past(word_d)));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             load_n,
    input  logic             upd,
    input  logic             clr_in,
    input  logic             clr_mid,
    output logic             sdo,
    output logic [WIDTH-1:0] code_out
);
    import sdac_pkg::*;

    logic [N_LANES-1:0] lvl, rise;
    logic [WIDTH-1:0]   word_d;

    always_comb begin
        lvl             = '0;
        lvl[LANE_SHIFT] = cs_n | sclk;
        lvl[LANE_UPD]   = upd;
        lvl[LANE_CLR]   = clr_in;
    end

    sdac_edge #(.N(N_LANES)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    sdac_shift #(.W(WIDTH)) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rise[LANE_SHIFT]),
        .din   (sdi),
        .word_d(word_d),
        .dout  (sdo)
    );

    sdac_regs #(.W(WIDTH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_d    (word_d),
        .follow    (!load_n),
        .xfer      (rise[LANE_UPD]),
        .preset    (rise[LANE_CLR]),
        .preset_mid(clr_mid),
        .code      (code_out)
    );

    a_r3_late_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cs_n && !sclk && !$past(cs_n) && !$past(sclk))
            |-> rise[LANE_SHIFT]);
endmodule

// File: tb/test_sdac_frontend.sv
`timescale 1ns/1ps
module test_sdac_frontend;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, load_n = 1'b1;
    logic upd = 1'b0, clr_in = 1'b0, clr_mid = 1'b0;
    logic sdo;
    logic [15:0] code_out;

    int checks = 0, errors = 0;
    bit  done = 1'b0;

    // reference model state
    logic [15:0] m_sh, m_in, m_out, m_old;
    logic m_pg, m_pu, m_pc, m_g, m_ge, m_ue, m_ce;

    always #2.5 clk = ~clk;

    sdac_frontend i_sdac_frontend (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .load_n(load_n), .upd(upd), .clr_in(clr_in), .clr_mid(clr_mid),
        .sdo(sdo), .code_out(code_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sh = '0; m_in = '0; m_out = '0;
            m_pg = 1'b1; m_pu = 1'b1; m_pc = 1'b1;
        end else begin
            m_g  = cs_n | sclk;
            m_ge = m_g && !m_pg;
            m_ue = upd && !m_pu;
            m_ce = clr_in && !m_pc;
            m_pg = m_g; m_pu = upd; m_pc = clr_in;
            m_old = m_in;
            if (m_ge) m_sh = {m_sh[14:0], sdi};
            if (m_ce) begin
                m_in  = clr_mid ? 16'h8000 : 16'h0000;
                m_out = m_in;
            end else begin
                if (!load_n) m_in = m_sh;
                if (m_ue) m_out = m_old;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 model code", code_out, m_out);
            chk("R9 model sdo", {15'd0, sdo}, {15'd0, m_sh[15]});
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sclk_bit(input logic b);
        sdi = b; sclk = 1'b0; step();
        sclk = 1'b1; step();
    endtask

    task automatic cs_bit(input logic b);
        sdi = b; cs_n = 1'b0; step();
        cs_n = 1'b1; step();
    endtask

    task automatic word_sclk(input logic [15:0] w);
        cs_n = 1'b0; step();
        for (int i = 15; i >= 0; i--) sclk_bit(w[i]);
        cs_n = 1'b1; step();
    endtask

    task automatic load_pulse();
        load_n = 1'b0; step(); load_n = 1'b1; step();
    endtask

    task automatic upd_pulse();
        upd = 1'b1; step(); upd = 1'b0; step();
    endtask

    task automatic clr_pulse(input logic mid);
        clr_mid = mid; clr_in = 1'b1; step(); clr_in = 1'b0; step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1; step();
        chk("R10 reset code", code_out, 16'h0000);
        chk("R10 reset sdo", {15'd0, sdo}, 16'h0000);

        clr_pulse(1'b1);
        chk("R7 mid preset", code_out, 16'h8000);
        clr_pulse(1'b0);
        chk("R7 zero preset", code_out, 16'h0000);

        word_sclk(16'hA5C3);
        chk("R6 no update yet", code_out, 16'h0000);
        chk("R9 sdo msb", {15'd0, sdo}, 16'h0001);
        upd_pulse();
        chk("R5 load high holds", code_out, 16'h0000);
        load_pulse(); upd_pulse();
        chk("R1 word through", code_out, 16'hA5C3);

        // shift by select toggling, serial clock held low
        sclk = 1'b0; step();
        for (int i = 15; i >= 0; i--) cs_bit(16'h3C96 >> i);
        sclk = 1'b1; step();
        load_pulse(); upd_pulse();
        chk("R2 select-clocked word", code_out, 16'h3C96);

        clr_pulse(1'b1);
        chk("R7 mid again", code_out, 16'h8000);
        load_pulse(); upd_pulse();
        chk("R8 shift kept over clear", code_out, 16'h3C96);

        // late select rise with clock low
        word_sclk(16'h1234);
        cs_n = 1'b0; step();
        sclk = 1'b0; sdi = 1'b1; step();
        cs_n = 1'b1; step();
        sclk = 1'b1; step();
        load_pulse(); upd_pulse();
        chk("R3 extra shift", code_out, 16'h2469);

        // transparency while shifting
        load_n = 1'b0; cs_n = 1'b0; step();
        sclk_bit(1'b1); sclk_bit(1'b0); sclk_bit(1'b1); sclk_bit(1'b1);
        upd_pulse();
        chk("R4 follows shifting", code_out, 16'h469B);
        load_n = 1'b1; step();

        // daisy chain walk of earlier contents
        for (int k = 0; k < 16; k++) begin
            chk("R9 chain bit", {15'd0, sdo}, {15'd0, 16'h469B >> (15 - k)} & 16'h0001);
            sclk_bit(1'b1);
        end
        cs_n = 1'b1; step();

        // held update strobe
        upd = 1'b1; step();
        chk("R6 level upd transfer", code_out, 16'h469B);
        load_n = 1'b0; step(); step();
        chk("R6 held upd no transfer", code_out, 16'h469B);
        load_n = 1'b1; upd = 1'b0; step();
        upd_pulse();
        chk("R6 new edge transfers", code_out, 16'hFFFF);

        // system reset with strobe already high
        upd = 1'b1; rst_n = 1'b0; step(); rst_n = 1'b1; step(); step();
        chk("R10 high strobe not an edge", code_out, 16'h0000);
        upd = 1'b0; step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule